// File: doc/BRIEF.md
# Shared Address/Data Flash Bus Front End

This block sits between a 16-bit bus that carries both address and data and the inside of a flash memory device. Each rising edge of `clk` samples the strobes: chip-enable `ce_n`, output-enable `oe_n`, write-enable `we_n` and address-valid `adv_n`, all active low. A five-state controller turns each sample into a bus state:

- `ST_DESEL`: chip deselected.
- `ST_OUTDIS`: selected, but the outputs are off.
- `ST_READ`: read in progress.
- `ST_WRITE`: write in progress.
- `ST_APS`: automatic power-saving standby.

The address is latched from the shared bus while address-valid is low. In synchronous mode the latch closes early, at the first qualifying clock edge. A write hands its address and the last data word seen on the bus to the command logic as a single-cycle pulse. This happens when the write ends, that is on the first rising edge of either write-enable or chip-enable.

During a read, the block drives a word from a built-in array model onto the bus. After a read has held its inputs unchanged for `APS_DLY` sampled edges, the block drops into automatic standby. Any change on the bus or on a strobe wakes it. The upper bits of the latched address are presented as a partition select. The transitions are:

- From any state, the decoded state is taken at the next edge.
- `ST_READ` to `ST_READ` while the inputs are unchanged, counting.
- `ST_READ` to `ST_APS` when the count ends.
- `ST_APS` to `ST_APS` while the inputs are unchanged.
- `ST_APS` to the decoded state on any change.

Top module: `mux_flash_front`

## Requirements
- R1: When an edge samples `ce_n`=0, `oe_n`=0, `we_n`=1, the block enters `ST_READ`. From the next cycle `bus_oe`=1 and `bus_o` carries the array word of the latched address A, which is {A[7:0],A[15:8]} XOR 16'hC3A5.
- R2: While `adv_n` is sampled low and the latch is open, the latch follows `bus_i` on every edge.
- R3: With `sync_mode`=0, the latch keeps the last value sampled while `adv_n` was low. Bus changes after `adv_n` rises do not alter it.
- R4: With `sync_mode`=1, the first edge that samples `adv_n`=0, `ce_n`=0, `we_n`=1 captures the bus and closes the latch. The latch then ignores the bus until `adv_n` is sampled high and then low again.
- R5: An edge sampling `ce_n`=0, `we_n`=0, `oe_n`=1 enters `ST_WRITE`. While in it, the bus is never driven.
- R6: Each write yields exactly one single-cycle `wr_valid` pulse. The pulse carries the latched address and the last bus value sampled in `ST_WRITE`, and it behaves the same whatever `sync_mode` is.
- R7: The write ends on the first edge that samples `we_n` high or `ce_n` high, whichever rises first. `wr_valid` is high in the cycle after that edge.
- R8: When `oe_n` is sampled high, the next cycle has `bus_oe`=0 and `bus_o`=0.
- R9: A read whose bus and strobes stay unchanged for `APS_DLY` edges after entering `ST_READ` enters `ST_APS`, which raises `aps_sleep`. The bus stays driven during `ST_APS`.
- R10: `part_sel` equals the top `PART_BITS` bits of the latched address.
- R11: `rst_n` low clears the latched address and any pending write and enters `ST_DESEL`. It holds `bus_oe`, `wr_valid` and `aps_sleep` at 0.
- R12: In `ST_APS`, any change on `bus_i` or on a strobe leaves `ST_APS` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, samples all strobes |
| rst_n | input | 1 | Device reset, active low |
| sync_mode | input | 1 | 1 selects synchronous address latching |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low |
| bus_i | input | 16 | Shared address/data bus, inbound |
| bus_o | output | 16 | Read data toward the bus |
| bus_oe | output | 1 | 1 drives the bus, 0 leaves it high-impedance |
| part_sel | output | PART_BITS | Partition selected by the upper address bits |
| aps_sleep | output | 1 | Automatic standby active |
| wr_valid | output | 1 | One-cycle write-capture pulse |
| wr_addr | output | 16 | Captured write address |
| wr_data | output | 16 | Captured write data |

## Verification
The bench builds the block with `APS_DLY`=4, so the standby entry and the wake-up fall inside a few cycles and can be checked on their exact edge. It also uses `PART_BITS`=3, so the test addresses, which differ in their top three bits, give distinct partition selects. The bench runs the same latch sequence in both modes to show the early synchronous close, ends one write on write-enable and one on chip-enable, and interrupts a third write with reset.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        ST_DESEL  = 3'd0,
        ST_OUTDIS = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_APS    = 3'd4
    } fe_state_e;

    // Array model: byte swap, then a fixed XOR mask
    function automatic logic [BUS_W-1:0] array_word(input logic [BUS_W-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'hC3A5;
    endfunction

endpackage

// File: rtl/fe_addr_latch.sv
module fe_addr_latch
    import fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic [BUS_W-1:0] bus_i,
    output logic [BUS_W-1:0] addr_q
);

    logic closed_q;
    logic sync_hit;

    assign sync_hit = sync_mode && !ce_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            closed_q <= 1'b0;
        end else if (adv_n) begin
            closed_q <= 1'b0;
        end else if (!closed_q) begin
            addr_q <= bus_i;
            if (sync_hit) closed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
    import fe_pkg::*;
#(
    parameter int APS_DLY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             adv_n,
    input  logic [BUS_W-1:0] bus_i,
    output fe_state_e        dec_st,
    output fe_state_e        state_q,
    output logic             drive,
    output logic             sleep
);

    localparam int CW    = $clog2(APS_DLY + 1);
    localparam int SNAPW = BUS_W + 4;

    fe_state_e        nxt;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [SNAPW-1:0] snap_q, snap_now;
    logic             chg;

    assign snap_now = {bus_i, ce_n, oe_n, we_n, adv_n};
    assign chg      = (snap_now != snap_q);

    // Strobe decode
    always_comb begin
        if (ce_n)               dec_st = ST_DESEL;
        else if (!we_n && oe_n) dec_st = ST_WRITE;
        else if (!oe_n && we_n) dec_st = ST_READ;
        else                    dec_st = ST_OUTDIS;
    end

    // Next state
    always_comb begin
        nxt   = dec_st;
        cnt_d = '0;
        unique case (state_q)
            ST_READ: begin
                if (dec_st == ST_READ && !chg) begin
                    if (cnt_q == CW'(APS_DLY - 1)) begin
                        nxt = ST_APS;
                    end else begin
                        nxt   = ST_READ;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_APS: begin
                if (dec_st == ST_READ && !chg) nxt = ST_APS;
            end
            ST_DESEL, ST_OUTDIS, ST_WRITE: begin
                nxt = dec_st;
            end
            default: nxt = ST_DESEL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            cnt_q   <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= nxt;
            cnt_q   <= cnt_d;
            snap_q  <= snap_now;
        end
    end

    // Outputs
    always_comb begin
        drive = 1'b0;
        sleep = 1'b0;
        unique case (state_q)
            ST_READ:  drive = 1'b1;
            ST_APS: begin
                drive = 1'b1;
                sleep = 1'b1;
            end
            ST_DESEL, ST_OUTDIS, ST_WRITE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/fe_write_cap.sv
module fe_write_cap
    import fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fe_state_e        state_q,
    input  fe_state_e        dec_st,
    input  logic [BUS_W-1:0] lat_addr,
    input  logic [BUS_W-1:0] bus_i,
    output logic             wr_valid,
    output logic [BUS_W-1:0] wr_addr,
    output logic [BUS_W-1:0] wr_data
);

    logic [BUS_W-1:0] dat_q;
    logic             ending;

    assign ending = (state_q == ST_WRITE) && (dec_st != ST_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q    <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= ending;
            if (dec_st == ST_WRITE) dat_q <= bus_i;
            if (ending) begin
                wr_addr <= lat_addr;
                wr_data <= dat_q;
            end
        end
    end

endmodule

// File: rtl/mux_flash_front.sv
module mux_flash_front
    import fe_pkg::*;
#(
    parameter int PART_BITS = 3,
    parameter int APS_DLY   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 adv_n,
    input  logic [15:0]          bus_i,
    output logic [15:0]          bus_o,
    output logic                 bus_oe,
    output logic [PART_BITS-1:0] part_sel,
    output logic                 aps_sleep,
    output logic                 wr_valid,
    output logic [15:0]          wr_addr,
    output logic [15:0]          wr_data
);

    logic [BUS_W-1:0] lat_addr;
    fe_state_e        dec_st;
    fe_state_e        state_q;

    fe_addr_latch u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .adv_n     (adv_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .bus_i     (bus_i),
        .addr_q    (lat_addr)
    );

    fe_ctrl #(.APS_DLY(APS_DLY)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .adv_n   (adv_n),
        .bus_i   (bus_i),
        .dec_st  (dec_st),
        .state_q (state_q),
        .drive   (bus_oe),
        .sleep   (aps_sleep)
    );

    fe_write_cap u_wcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .dec_st   (dec_st),
        .lat_addr (lat_addr),
        .bus_i    (bus_i),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign bus_o    = bus_oe ? array_word(lat_addr) : '0;
    assign part_sel = lat_addr[BUS_W-1 -: PART_BITS];

endmodule

// File: rtl/fe_front_chk.sv
module fe_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sync_mode,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        adv_n,
    input logic [15:0] bus_i,
    input logic [15:0] bus_o,
    input logic        bus_oe,
    input logic        aps_sleep,
    input logic        wr_valid,
    input logic [15:0] lat_addr
);

    // R1: bus driven only after a read-qualifying sample
    a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!ce_n && !oe_n && we_n));

    // R8: output-enable high releases the bus
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n) |-> (!bus_oe && bus_o == 16'h0000));

    // R4: synchronous latch stays closed while address-valid stays low
    a_r4_sync_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !adv_n && $past(sync_mode && !adv_n && !ce_n && we_n))
        |=> $stable(lat_addr));

    // R6: write capture is a single-cycle pulse
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7: pulse follows a write-enable or chip-enable rise
    a_r7_end_edge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(ce_n || we_n) && $past(!we_n, 2)));

    // R9: standby entered only after unchanged bus
    a_r9_quiet_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aps_sleep) |-> ($past(bus_i) == $past(bus_i, 2)));

    // R12: bus change wakes standby
    a_r12_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (aps_sleep && bus_i != $past(bus_i)) |=> !aps_sleep);

    // R11: reset keeps outputs quiet
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_oe && !wr_valid && !aps_sleep));

endmodule

bind mux_flash_front fe_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .adv_n     (adv_n),
    .bus_i     (bus_i),
    .bus_o     (bus_o),
    .bus_oe    (bus_oe),
    .aps_sleep (aps_sleep),
    .wr_valid  (wr_valid),
    .lat_addr  (lat_addr)
);

// File: tb/mux_flash_front_tb.sv
module mux_flash_front_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PB         = 3;
    localparam int DLY        = 4;

    logic          clk = 1'b0;
    logic          rst_n, sync_mode, ce_n, oe_n, we_n, adv_n;
    logic [15:0]   bus_i;
    logic [15:0]   bus_o, wr_addr, wr_data;
    logic          bus_oe, aps_sleep, wr_valid;
    logic [PB-1:0] part_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_flash_front #(.PART_BITS(PB), .APS_DLY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .adv_n(adv_n), .bus_i(bus_i),
        .bus_o(bus_o), .bus_oe(bus_oe), .part_sel(part_sel),
        .aps_sleep(aps_sleep), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [15:0] model_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hC3A5;
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor for write captures
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6: actual=%h expected=none", {wr_addr, wr_data});
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    bad++;
                    $display("FAIL R6: actual=%h expected=%h", {wr_addr, wr_data}, e);
                end
            end
        end
    end

    // Driver: address phase then data phase; ends on we (by_ce=0) or ce (by_ce=1)
    task automatic do_write(input logic [15:0] a, input logic [15:0] d0,
                            input logic [15:0] d1, input bit by_ce);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; adv_n = 1'b0; bus_i = a;
        step();
        adv_n = 1'b1; step();
        we_n = 1'b0; bus_i = d0; step();
        chk("R5 no drive in write", {31'd0, bus_oe}, 32'd0);
        bus_i = d1; step();
        exp_q.push_back({a, d1});
        if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
        step();
        chk("R7 pulse after end edge", {31'd0, wr_valid}, 32'd1);
        we_n = 1'b1; ce_n = 1'b1; step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sync_mode = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        we_n = 1'b1; adv_n = 1'b1; bus_i = 16'h0;
        step(3);
        chk("R11 reset bus_oe", {31'd0, bus_oe}, 32'd0);
        chk("R11 reset wr_valid", {31'd0, wr_valid}, 32'd0);
        chk("R11 reset part_sel", {29'd0, part_sel}, 32'd0);
        rst_n = 1'b1; step();

        // Async read
        ce_n = 1'b0; adv_n = 1'b0; bus_i = 16'h2345; step();
        chk("R10 part_sel", {29'd0, part_sel}, 32'd1);
        bus_i = 16'hA1B2; step();
        chk("R2 transparent", {29'd0, part_sel}, 32'd5);
        adv_n = 1'b1; bus_i = 16'hFFFF; step();
        chk("R3 async hold", {29'd0, part_sel}, 32'd5);
        oe_n = 1'b0; step();
        chk("R1 drive", {31'd0, bus_oe}, 32'd1);
        chk("R1 data", {16'd0, bus_o}, {16'd0, model_word(16'hA1B2)});
        step(DLY - 1);
        chk("R9 not yet asleep", {31'd0, aps_sleep}, 32'd0);
        step();
        chk("R9 asleep", {31'd0, aps_sleep}, 32'd1);
        chk("R9 still driving", {31'd0, bus_oe}, 32'd1);
        bus_i = 16'h1111; step();
        chk("R12 wake", {31'd0, aps_sleep}, 32'd0);
        oe_n = 1'b1; step();
        chk("R8 release oe", {31'd0, bus_oe}, 32'd0);
        chk("R8 bus_o zero", {16'd0, bus_o}, 32'd0);

        // Sync read: first qualifying edge closes the latch
        sync_mode = 1'b1; adv_n = 1'b0; bus_i = 16'hC00C; step();
        bus_i = 16'h4DD4; step();
        chk("R4 sync closed", {29'd0, part_sel}, 32'd6);
        adv_n = 1'b1; oe_n = 1'b0; step();
        chk("R4 sync data", {16'd0, bus_o}, {16'd0, model_word(16'hC00C)});
        oe_n = 1'b1; adv_n = 1'b0; bus_i = 16'h6006; step();
        chk("R4 reopen", {29'd0, part_sel}, 32'd3);
        adv_n = 1'b1; ce_n = 1'b1; step();

        // Writes: ended by we, by ce, in both modes
        sync_mode = 1'b0;
        do_write(16'h8123, 16'h0F0F, 16'hBEEF, 1'b0);
        sync_mode = 1'b1;
        do_write(16'hE456, 16'h1234, 16'h5678, 1'b1);

        // Reset in mid-write: no capture
        sync_mode = 1'b0;
        ce_n = 1'b0; adv_n = 1'b0; bus_i = 16'h7777; step();
        adv_n = 1'b1; we_n = 1'b0; bus_i = 16'h9999; step();
        rst_n = 1'b0; step();
        chk("R11 reset clears latch", {29'd0, part_sel}, 32'd0);
        we_n = 1'b1; ce_n = 1'b1; step();
        rst_n = 1'b1; step(2);
        chk("R11 no pending write", {31'd0, wr_valid}, 32'd0);

        chk("R6 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule